// File: doc/BRIEF.md
# Multi-mode DDR input deserializer gearbox

This block turns a serial line, sampled on both edges of a fast edge clock, into parallel words on a slow system clock. The mode input is static and selects one of three layouts. The first is a 7-bit word. The second is an 8-bit word. The third is a pair of independent 4-bit lanes that share the 8-bit output. The second lane has its own serial input and its own slip request, and both are used only in the dual layout.

Each lane has two parts. A fast-domain capture stage keeps a running bit count and a 16-bit history of the line. A slow-domain aligner reads that count at every slow edge and takes the next full word at its current boundary. A core-driven slip request moves the boundary one bit later, which discards one bit. The phases of the two clocks are locked, so the output register loads at most once per slow cycle.

Top module: `ddr_gearbox_deser`

## Requirements
- R1: `mode_sel` selects the layout. 2'b00 and 2'b11 give one 8-bit word on `par_out[7:0]`. 2'b01 gives a 7-bit word on `par_out[6:0]` with `par_out[7]` held at 0. 2'b10 gives two 4-bit lanes: lane A (`ser_in[0]`, `slip_req[0]`) drives `par_out[7:4]` and lane B (`ser_in[1]`, `slip_req[1]`) drives `par_out[3:0]`.
- R2: Within a lane, the earliest received bit of a word sits in the lane's least significant position. Later bits follow in arrival order.
- R3: One bit is captured on every edge of `clk_fast`, rising and falling alike, so each fast clock period delivers two bits per lane.
- R4: While `rst` is high at a rising `clk_slow` edge, `par_out` is zero. It stays zero until the first word, which holds the first W bits captured on `clk_fast` edges after `rst` went low.
- R5: Whenever at least W uncollected bits are present at a rising `clk_slow` edge, the next W bits are loaded into `par_out` at that edge. With W bits arriving per slow period, the output advances by one word per cycle.
- R6: A slip request seen high at a rising `clk_slow` edge while the lane is not blocked moves that lane's boundary one bit later. The word that follows starts one bit further on in the stream.
- R7: After a slip is accepted, further requests on that lane are ignored until a word has been loaded at a later edge.
- R8: If a slip leaves fewer than W uncollected bits at an edge, that lane's part of `par_out` keeps its previous value for that cycle. It resumes at the next edge.
- R9: Outside mode 2'b10, lane B is held in reset, and `ser_in[1]` and `slip_req[1]` have no effect on `par_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow system clock; `par_out` updates on its rising edge |
| clk_fast | input | 1 | Fast edge clock; both edges sample the serial lines |
| rst | input | 1 | Synchronous active-high reset for both domains |
| mode_sel | input | 2 | Static layout select (see R1) |
| ser_in | input | 2 | Serial data; bit 0 is lane A, bit 1 is lane B |
| slip_req | input | 2 | One-bit boundary slip request per lane, in the slow domain |
| par_out | output | 8 | Parallel word |

## Verification
The checks assume that `mode_sel` changes only while `rst` is high. They also assume that both clocks are phase-locked, with W fast-clock edges per slow period and no fast edge falling on a rising slow edge. The bench derives every fast edge from the start time of the current slow period and places it half a bit slot off that start, so no edge drifts onto a slow edge. It switches the mode only in the same cycle as it raises reset. The serial data it drives is already valid half a bit slot before the edge that samples it.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;

    localparam int WORD_MAX = 8;
    localparam int CNT_W    = 8;
    localparam int HIST_W   = 2 * WORD_MAX;
    localparam int HIDX_W   = $clog2(HIST_W);
    localparam int WSEL_W   = $clog2(WORD_MAX + 1);

    typedef enum logic [1:0] {
        GB_X8    = 2'b00,
        GB_X7    = 2'b01,
        GB_DUAL4 = 2'b10,
        GB_X8ALT = 2'b11
    } gb_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HIST_W-1:0] hist;
    } cap_t;

    function automatic logic [WSEL_W-1:0] lane_width(gb_mode_e m, int lane);
        logic [WSEL_W-1:0] w;
        if (lane != 0 || m == GB_DUAL4) w = WSEL_W'(WORD_MAX / 2);
        else if (m == GB_X7)            w = WSEL_W'(WORD_MAX - 1);
        else                            w = WSEL_W'(WORD_MAX);
        return w;
    endfunction

    // lag: bits received beyond the boundary; the oldest wanted bit sits at hist[lag-1]
    function automatic logic [WORD_MAX-1:0] pick_word(logic [HIST_W-1:0] h,
                                                      logic [CNT_W-1:0]  lag,
                                                      logic [WSEL_W-1:0] w);
        logic [WORD_MAX-1:0] r;
        logic [CNT_W-1:0]    idx;
        r = '0;
        for (int j = 0; j < WORD_MAX; j++) begin
            idx = lag - CNT_W'(1) - CNT_W'(j);
            if (WSEL_W'(j) < w) r[j] = h[idx[HIDX_W-1:0]];
        end
        return r;
    endfunction

endpackage

// File: rtl/gbx_ddr_capture.sv
`timescale 1ns/1ps
module gbx_ddr_capture
    import gbx_pkg::*;
(
    input  logic clk_fast,
    input  logic rst,
    input  logic din,
    output cap_t cap
);

    logic [CNT_W-1:0]  cnt_rise, cnt_fall;
    logic [HIST_W-1:0] hist_rise, hist_fall;

    // each edge extends the history written by the opposite edge
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            cnt_rise  <= '0;
            hist_rise <= '0;
        end else begin
            cnt_rise  <= cnt_fall + CNT_W'(1);
            hist_rise <= {hist_fall[HIST_W-2:0], din};
        end
    end

    always_ff @(negedge clk_fast) begin
        if (rst) begin
            cnt_fall  <= '0;
            hist_fall <= '0;
        end else begin
            cnt_fall  <= cnt_rise + CNT_W'(1);
            hist_fall <= {hist_rise[HIST_W-2:0], din};
        end
    end

    // the copy written most recently is one count ahead of the other
    always_comb begin
        if (cnt_rise == cnt_fall + CNT_W'(1)) begin
            cap.cnt  = cnt_rise;
            cap.hist = hist_rise;
        end else begin
            cap.cnt  = cnt_fall;
            cap.hist = hist_fall;
        end
    end

endmodule

// File: rtl/gbx_word_align.sv
`timescale 1ns/1ps
module gbx_word_align
    import gbx_pkg::*;
(
    input  logic                clk_slow,
    input  logic                rst,
    input  logic [WSEL_W-1:0]   wsel,
    input  logic                slip,
    input  cap_t                cap,
    output logic [WORD_MAX-1:0] word
);

    logic [CNT_W-1:0] bnd;
    logic             blocked;
    logic [CNT_W-1:0] lag;
    logic             ready;
    logic             take;
    logic [CNT_W-1:0] step;

    always_comb begin
        lag   = cap.cnt - bnd;
        ready = !lag[CNT_W-1] && (lag >= CNT_W'(wsel));
        take  = slip && !blocked;
        step  = (ready ? CNT_W'(wsel) : '0) + (take ? CNT_W'(1) : '0);
    end

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            bnd     <= '0;
            blocked <= 1'b0;
            word    <= '0;
        end else begin
            bnd <= bnd + step;
            if (ready) word <= pick_word(cap.hist, lag, wsel);
            if (take)       blocked <= 1'b1;
            else if (ready) blocked <= 1'b0;
        end
    end

endmodule

// File: rtl/gbx_lane.sv
`timescale 1ns/1ps
module gbx_lane
    import gbx_pkg::*;
(
    input  logic                clk_slow,
    input  logic                clk_fast,
    input  logic                rst,
    input  logic [WSEL_W-1:0]   wsel,
    input  logic                din,
    input  logic                slip,
    output logic [WORD_MAX-1:0] word
);

    cap_t cap;

    gbx_ddr_capture u_cap (
        .clk_fast (clk_fast),
        .rst      (rst),
        .din      (din),
        .cap      (cap)
    );

    gbx_word_align u_align (
        .clk_slow (clk_slow),
        .rst      (rst),
        .wsel     (wsel),
        .slip     (slip),
        .cap      (cap),
        .word     (word)
    );

endmodule

// File: rtl/ddr_gearbox_deser.sv
`timescale 1ns/1ps
module ddr_gearbox_deser
    import gbx_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int OUT_W = WORD_MAX
) (
    input  logic             clk_slow,
    input  logic             clk_fast,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [NLANE-1:0] ser_in,
    input  logic [NLANE-1:0] slip_req,
    output logic [OUT_W-1:0] par_out
);

    localparam int HALF = OUT_W / 2;

    gb_mode_e            mode;
    logic [WORD_MAX-1:0] lane_word [NLANE];

    assign mode = gb_mode_e'(mode_sel);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic lane_rst;
        // lanes above the first only run in the dual layout
        if (l == 0) begin : g_main
            assign lane_rst = rst;
        end else begin : g_aux
            assign lane_rst = rst || (mode != GB_DUAL4);
        end

        gbx_lane u_lane (
            .clk_slow (clk_slow),
            .clk_fast (clk_fast),
            .rst      (lane_rst),
            .wsel     (lane_width(mode, l)),
            .din      (ser_in[l]),
            .slip     (slip_req[l]),
            .word     (lane_word[l])
        );
    end

    always_comb begin
        case (mode)
            GB_X7:    par_out = {1'b0, lane_word[0][OUT_W-2:0]};
            GB_DUAL4: par_out = {lane_word[0][HALF-1:0], lane_word[1][HALF-1:0]};
            default:  par_out = lane_word[0][OUT_W-1:0];
        endcase
    end

endmodule

// File: rtl/ddr_gearbox_deser_chk.sv
`timescale 1ns/1ps
module ddr_gearbox_deser_chk (
    input logic       clk_slow,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic [7:0] par_out,
    input logic [7:0] lane1_word
);

    AST_OUT_CLEAR_AFTER_RST: assert property (@(posedge clk_slow) disable iff (rst)
        $fell(rst) |-> par_out == 8'h00); // R4

    AST_X7_MSB_IDLE: assert property (@(posedge clk_slow) disable iff (rst)
        mode_sel == 2'b01 |-> !par_out[7]); // R1

    AST_MODE_HELD: assert property (@(posedge clk_slow) disable iff (rst)
        !$past(rst) |-> $stable(mode_sel)); // R1

    AST_LANE_B_PARKED: assert property (@(posedge clk_slow) disable iff (rst)
        mode_sel != 2'b10 |=> lane1_word == 8'h00); // R9

endmodule

bind ddr_gearbox_deser ddr_gearbox_deser_chk u_chk (
    .clk_slow   (clk_slow),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .par_out    (par_out),
    .lane1_word (lane_word[1])
);

// File: tb/ddr_gearbox_deser_tb.sv
`timescale 1ns/1ps
module ddr_gearbox_deser_tb;

    localparam int P  = 4;
    localparam int NB = 1024;

    logic       clk_slow = 1'b0;
    logic       clk_fast = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] ser_in = 2'b00;
    logic [1:0] slip_req = 2'b00;
    logic [7:0] par_out;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    int  gper = 0;
    int  ph_start = 1000000;
    int  w_cur = 8;
    bit  bits_a [NB];
    bit  bits_b [NB];

    int         bnd [2];
    bit         blk [2];
    logic [7:0] lw  [2];

    ddr_gearbox_deser u_dut (
        .clk_slow (clk_slow),
        .clk_fast (clk_fast),
        .rst      (rst),
        .mode_sel (mode_sel),
        .ser_in   (ser_in),
        .slip_req (slip_req),
        .par_out  (par_out)
    );

    always #10 clk_slow = ~clk_slow;

    task automatic wait_to(input real t);
        if (t > $realtime) #(t - $realtime);
    endtask

    // fast clock and serial data, W edges per slow period, locked to each slow edge
    initial begin
        forever begin
            real t0, half;
            int  per, w;
            @(posedge clk_slow);
            t0   = $realtime;
            gper = gper + 1;
            per  = gper - ph_start;
            w    = w_cur;
            half = 10.0 / w;
            if (per == P) begin
                #0.1;
                rst = 1'b0;
            end
            for (int i = 0; i < w; i++) begin
                wait_to(t0 + 2.0 * i * half);
                if (per >= P) begin
                    int n;
                    n = (per - P) * w + i;
                    ser_in = {bits_b[n], bits_a[n]};
                end else begin
                    ser_in = 2'b00;
                end
                wait_to(t0 + (2.0 * i + 1.0) * half);
                clk_fast = ~clk_fast;
            end
        end
    end

    function automatic bit get_bit(input int l, input int n);
        return (l == 0) ? bits_a[n] : bits_b[n];
    endfunction

    // reference for one lane at one slow edge
    task automatic model_lane(input int l, input int w, input int c, input bit al, inout string tag);
        int  avail;
        bit  wd, acc;
        avail = c - bnd[l];
        wd    = (avail >= w);
        acc   = al && !blk[l];
        if (wd) begin
            lw[l] = 8'h00;
            for (int j = 0; j < w; j++) lw[l][j] = get_bit(l, bnd[l] + j); // R2 order
        end
        if (!wd)                  tag = "R8";
        else if (al && blk[l] && tag != "R8") tag = "R7";
        else if (acc && tag == "") tag = "R6";
        if (acc)     blk[l] = 1'b1;
        else if (wd) blk[l] = 1'b0;
        bnd[l] = bnd[l] + (wd ? w : 0) + (acc ? 1 : 0);
    endtask

    task automatic check(input string tag, input int per, input logic [7:0] exp);
        total++;
        if (par_out !== exp) begin
            bad++;
            $display("FAIL %s per=%0d got=%h exp=%h", tag, per, par_out, exp);
        end
    endtask

    task automatic run_phase(input logic [1:0] m, input int nper);
        int         w;
        logic [1:0] al_prev;
        w = (m == 2'b01) ? 7 : (m == 2'b10) ? 4 : 8;
        for (int n = 0; n < NB; n++) begin
            bits_a[n] = 1'($urandom);
            bits_b[n] = 1'($urandom);
        end
        @(negedge clk_slow);
        mode_sel = m;
        rst      = 1'b1;
        slip_req = 2'b00;
        w_cur    = w;
        ph_start = gper + 1;
        for (int l = 0; l < 2; l++) begin
            bnd[l] = 0;
            blk[l] = 1'b0;
            lw[l]  = 8'h00;
        end
        al_prev = 2'b00;
        for (int per = 0; per < nper; per++) begin
            string      tag;
            logic [7:0] exp;
            @(negedge clk_slow);
            tag = "";
            if (per >= P + 1) begin
                int c;
                c = (per - P) * w;
                model_lane(0, w, c, al_prev[0], tag);
                if (m == 2'b10) model_lane(1, w, c, al_prev[1], tag);
            end
            case (m)
                2'b01:   exp = {1'b0, lw[0][6:0]};
                2'b10:   exp = {lw[0][3:0], lw[1][3:0]};
                default: exp = lw[0];
            endcase
            if (per <= P)                          tag = "R4";
            else if (tag == "" && m != 2'b10 && al_prev[1]) tag = "R9";
            else if (tag == "") begin
                case (m)
                    2'b00:   tag = "R5";
                    2'b01:   tag = "R1";
                    2'b10:   tag = "R3";
                    default: tag = "R2";
                endcase
            end
            check(tag, per, exp);
            // slip stimulus: random, plus a held three-cycle request on lane A (R7)
            if (per >= P && (per < P + 6 || per > P + 16)) begin
                slip_req[0] = ($urandom % 8) == 0;
                slip_req[1] = ($urandom % 6) == 0;
            end else if (per >= P + 10 && per <= P + 12) begin
                slip_req = 2'b01;
            end else begin
                slip_req = 2'b00;
            end
            al_prev = slip_req;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        run_phase(2'b00, 60);
        run_phase(2'b01, 60);
        run_phase(2'b10, 60);
        run_phase(2'b11, 40);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule